// File: doc/BRIEF.md
# ADC Conversion Start Trigger Selector

This block decides when an ADC controller begins a new conversion sequence. A start can come from software or from hardware. Software gives a one-cycle strobe when its start bit is written. The hardware source is either one of several timer waveform outputs or an external trigger pin. A select field picks the hardware source and an enable bit gates it. The software strobe works at all times, including while hardware triggering is enabled.

The hardware sources are asynchronous to the system clock. The chosen source is synchronized and edge detected in the system clock domain, so only a rising edge counts as a start. Each start request is then carried into the ADC clock domain with a toggle handshake. There it becomes a one-cycle start pulse. Requests that arrive while a handshake is still in flight are counted in a small backlog and sent one after another. None is lost and none is duplicated.

A busy flag in the system clock domain shows that at least one request has not yet been delivered. Register decoding, timer setup and the converter itself belong to other blocks. The control fields arrive here as plain inputs.

Top module: `conv_trigger_select`

## Requirements
- R1: A one-cycle high on `sw_start` produces exactly one `start_pulse`, whatever the values of `hw_enable` and `src_sel`.
- R2: While `hw_enable` is 1, a rising edge on the selected hardware source produces exactly one `start_pulse`. Select code 0..5 picks `timer_trig[code]` and code 6 picks `ext_trig`.
- R3: A hardware source held high gives no further start after its first one, and a falling edge gives no start.
- R4: While `hw_enable` is 0, edges on any hardware source produce no start.
- R5: Edges on hardware sources that are not selected produce no start.
- R6: Select code 7 is reserved and never produces a hardware start.
- R7: Changing `src_sel` creates no start by itself, even when the newly selected source is already high. For 3 system cycles after the change, edges are not detected.
- R8: `start_pulse` is high for exactly one `adc_clk` cycle per start.
- R9: Requests issued on consecutive system clock cycles each produce their own `start_pulse`, one per request. Up to 7 requests can be waiting.
- R10: From an idle state, `start_pulse` rises no later than 4 system clock periods plus 4 ADC clock periods after the request is presented at the inputs.
- R11: `busy` is 0 after reset. It is 1 in the cycle after a request is accepted, and returns to 0 once every request has been delivered.
- R12: During reset and directly after it, `start_pulse` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| adc_clk | input | 1 | ADC clock |
| adc_rst | input | 1 | Synchronous active-high reset, ADC domain |
| sw_start | input | 1 | Software start strobe, one system cycle |
| hw_enable | input | 1 | Enables the selected hardware source |
| src_sel | input | 3 | Hardware source code: 0..5 timers, 6 external, 7 reserved |
| timer_trig | input | 6 | Asynchronous timer waveform outputs |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| start_pulse | output | 1 | One-cycle start pulse, ADC domain |
| busy | output | 1 | Requests not yet delivered, system domain |

## Verification
The bench holds a source high for a long time to catch a design that detects levels and keeps firing. It switches the select onto a source that is already high to catch a detector that is not re-armed on a change and reports a false edge. It toggles sources that are not selected or are gated off, and uses the reserved code, to expose a mux or gate that leaks. It fires three software starts on consecutive cycles to show a handshake that drops or repeats requests, and it checks pulse width and latency to reveal a crossing stage that is too slow or a pulse that lasts two cycles.

// File: rtl/trig_pkg.sv
package trig_pkg;

  // Returns bit idx of a source vector, or 0 when idx is outside the
  // populated range (reserved select codes).
  function automatic logic pick_bit(input logic [31:0] vec,
                                    input int unsigned idx,
                                    input int unsigned n);
    logic r;
    r = 1'b0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < n && i == idx) r = vec[i];
    end
    return r;
  endfunction

endpackage

// File: rtl/trig_edge_detect.sv
module trig_edge_detect #(
  parameter int unsigned NSRC        = 7,
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_vec,
  input  logic [SEL_W-1:0] sel,
  input  logic             enable,
  output logic             edge_o
);
  localparam int unsigned SETTLE = SYNC_STAGES + 1;
  localparam int unsigned CNT_W  = $clog2(SETTLE + 1);

  logic [SEL_W-1:0]       sel_q;
  logic [CNT_W-1:0]       settle_cnt;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   raw;
  logic                   sel_chg;

  assign sel_chg = (sel != sel_q);
  assign raw     = trig_pkg::pick_bit(32'(src_vec), 32'(sel_q), NSRC);

  // Select register and settle window: on any select change the detector
  // ignores edges until the synchronizer holds only the new source.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= '0;
      settle_cnt <= CNT_W'(SETTLE);
    end else if (sel_chg) begin
      sel_q      <= sel;
      settle_cnt <= CNT_W'(SETTLE);
    end else if (settle_cnt != '0) begin
      settle_cnt <= settle_cnt - 1'b1;
    end
  end

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else     sync_q[g] <= raw;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      edge_o <= 1'b0;
    end else begin
      prev_q <= sync_q[SYNC_STAGES-1];
      edge_o <= enable && !sel_chg && (settle_cnt == '0)
                && sync_q[SYNC_STAGES-1] && !prev_q;
    end
  end

endmodule

// File: rtl/trig_cdc_tx.sv
module trig_cdc_tx #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BACKLOG_W   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_req,
  input  logic hw_req,
  input  logic ack_tog_i,
  output logic req_tog_o,
  output logic busy_o
);
  localparam int unsigned TOT_W = BACKLOG_W + 2;
  localparam logic [TOT_W-1:0] MAX_WAIT = TOT_W'((1 << BACKLOG_W) - 1);

  logic [SYNC_STAGES-1:0] ack_q;
  logic [BACKLOG_W-1:0]   backlog_q;
  logic [BACKLOG_W-1:0]   backlog_d;
  logic [TOT_W-1:0]       total;
  logic [TOT_W-1:0]       remain;
  logic                   in_flight;
  logic                   launch;
  logic                   tog_d;
  logic                   ack_d;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_ack
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) ack_q[g] <= 1'b0;
        else     ack_q[g] <= ack_tog_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) ack_q[g] <= 1'b0;
        else     ack_q[g] <= ack_q[g-1];
      end
    end
  end

  always_comb begin
    in_flight = (req_tog_o != ack_q[SYNC_STAGES-1]);
    total     = TOT_W'(backlog_q) + TOT_W'(sw_req) + TOT_W'(hw_req);
    launch    = !in_flight && (total != '0);
    remain    = total - TOT_W'(launch);
    backlog_d = (remain > MAX_WAIT) ? MAX_WAIT[BACKLOG_W-1:0]
                                    : remain[BACKLOG_W-1:0];
    tog_d     = req_tog_o ^ launch;
    ack_d     = ack_q[SYNC_STAGES-2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_tog_o <= 1'b0;
      backlog_q <= '0;
      busy_o    <= 1'b0;
    end else begin
      req_tog_o <= tog_d;
      backlog_q <= backlog_d;
      busy_o    <= (tog_d != ack_d) || (backlog_d != '0);
    end
  end

endmodule

// File: rtl/trig_cdc_rx.sv
module trig_cdc_rx #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_tog_i,
  output logic start_o,
  output logic ack_tog_o
);
  logic [SYNC_STAGES-1:0] tog_q;
  logic                   last_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_req
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) tog_q[g] <= 1'b0;
        else     tog_q[g] <= req_tog_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) tog_q[g] <= 1'b0;
        else     tog_q[g] <= tog_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= 1'b0;
      start_o <= 1'b0;
    end else begin
      last_q  <= tog_q[SYNC_STAGES-1];
      start_o <= tog_q[SYNC_STAGES-1] ^ last_q;
    end
  end

  assign ack_tog_o = last_q;

endmodule

// File: rtl/conv_trigger_select.sv
module conv_trigger_select #(
  parameter int unsigned NUM_TIMERS  = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BACKLOG_W   = 3
) (
  input  logic                  sys_clk,
  input  logic                  sys_rst,
  input  logic                  adc_clk,
  input  logic                  adc_rst,
  input  logic                  sw_start,
  input  logic                  hw_enable,
  input  logic [2:0]            src_sel,
  input  logic [NUM_TIMERS-1:0] timer_trig,
  input  logic                  ext_trig,
  output logic                  start_pulse,
  output logic                  busy
);
  localparam int unsigned NSRC  = NUM_TIMERS + 1;
  localparam int unsigned SEL_W = 3;

  logic [NSRC-1:0] src_vec;
  logic            hw_edge;
  logic            req_tog;
  logic            ack_tog;

  assign src_vec = {ext_trig, timer_trig};

  trig_edge_detect #(
    .NSRC(NSRC), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk(sys_clk), .rst(sys_rst), .src_vec(src_vec), .sel(src_sel),
    .enable(hw_enable), .edge_o(hw_edge)
  );

  trig_cdc_tx #(
    .SYNC_STAGES(SYNC_STAGES), .BACKLOG_W(BACKLOG_W)
  ) u_tx (
    .clk(sys_clk), .rst(sys_rst), .sw_req(sw_start), .hw_req(hw_edge),
    .ack_tog_i(ack_tog), .req_tog_o(req_tog), .busy_o(busy)
  );

  trig_cdc_rx #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_rx (
    .clk(adc_clk), .rst(adc_rst), .req_tog_i(req_tog),
    .start_o(start_pulse), .ack_tog_o(ack_tog)
  );

endmodule

// File: rtl/trig_checker.sv
module trig_checker #(
  parameter int unsigned NSRC = 7
) (
  input logic       sys_clk,
  input logic       sys_rst,
  input logic       adc_clk,
  input logic       adc_rst,
  input logic       sw_start,
  input logic       hw_enable,
  input logic [2:0] src_sel,
  input logic       hw_edge,
  input logic       start_pulse,
  input logic       busy
);

  AST_PULSE_SINGLE: assert property (@(posedge adc_clk) disable iff (adc_rst)
    start_pulse |=> !start_pulse); // R8

  AST_EDGE_SINGLE: assert property (@(posedge sys_clk) disable iff (sys_rst)
    hw_edge |=> !hw_edge); // R3

  AST_GATED_OFF: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (!hw_enable && !$past(hw_enable)) |-> !hw_edge); // R4

  AST_RESERVED_SILENT: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (32'(src_sel) >= NSRC && 32'($past(src_sel)) >= NSRC) |-> !hw_edge); // R6

  AST_BUSY_ON_REQ: assert property (@(posedge sys_clk) disable iff (sys_rst)
    sw_start |=> busy); // R11

endmodule

bind conv_trigger_select trig_checker #(.NSRC(NSRC)) u_chk (
  .sys_clk(sys_clk), .sys_rst(sys_rst), .adc_clk(adc_clk), .adc_rst(adc_rst),
  .sw_start(sw_start), .hw_enable(hw_enable), .src_sel(src_sel),
  .hw_edge(hw_edge), .start_pulse(start_pulse), .busy(busy)
);

// File: tb/conv_trigger_select_bench.sv
module conv_trigger_select_bench;
  localparam realtime SYS_T  = 8ns;
  localparam realtime ADC_T  = 20ns;
  localparam realtime LAT_NS = 4*SYS_T + 4*ADC_T + ADC_T/2;

  logic       sys_clk = 0, adc_clk = 0;
  logic       sys_rst = 1, adc_rst = 1;
  logic       sw_start = 0, hw_enable = 0, ext_trig = 0;
  logic [2:0] src_sel = 0;
  logic [5:0] timer_trig = 0;
  logic       start_pulse, busy;

  always #(SYS_T/2) sys_clk = ~sys_clk;
  always #(ADC_T/2) adc_clk = ~adc_clk;

  conv_trigger_select u_conv_trigger_select (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .adc_clk(adc_clk), .adc_rst(adc_rst),
    .sw_start(sw_start), .hw_enable(hw_enable), .src_sel(src_sel),
    .timer_trig(timer_trig), .ext_trig(ext_trig),
    .start_pulse(start_pulse), .busy(busy)
  );

  typedef struct {
    string   tag;
    realtime t;
    bit      chk_lat;
  } exp_t;

  exp_t  q[$];
  int    checks = 0, fails = 0;
  string cur_tag = "R12";
  bit    prev_pulse = 0;
  bit    done = 0;

  // Monitor: every start pulse must match a queued expectation.
  always @(negedge adc_clk) begin
    if (!adc_rst) begin
      if (start_pulse) begin
        checks++;
        if (prev_pulse) begin
          fails++;
          $display("FAIL R8: start_pulse width actual >=2 expected 1 cycle");
        end
        if (q.size() == 0) begin
          fails++;
          $display("FAIL %s: start_pulse actual 1 expected 0 (nothing pending)", cur_tag);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.chk_lat && ($realtime - e.t) > LAT_NS) begin
            fails++;
            $display("FAIL R10 (%s): latency actual %0t expected <= %0t",
                     e.tag, $realtime - e.t, LAT_NS);
          end
        end
      end
      prev_pulse = start_pulse;
    end
  end

  task automatic expect_start(string tag, bit lat);
    exp_t e;
    e.tag = tag; e.t = $realtime; e.chk_lat = lat;
    q.push_back(e);
  endtask

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic drain(string tag);
    idle(80);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL %s: missing starts actual %0d expected 0 pending", tag, q.size());
      q.delete();
    end
    check({tag, " busy idle (R11)"}, busy, 1'b0);
  endtask

  task automatic sw_pulse(string tag, bit lat);
    @(negedge sys_clk);
    sw_start = 1;
    expect_start(tag, lat);
    @(negedge sys_clk);
    sw_start = 0;
    check({tag, " busy after request (R11)"}, busy, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge adc_clk);
    check("R12 start_pulse in reset", start_pulse, 1'b0);
    check("R12 busy in reset", busy, 1'b0);
    @(negedge sys_clk); sys_rst = 0;
    @(negedge adc_clk); adc_rst = 0;
    idle(4);
    check("R12 start_pulse after reset", start_pulse, 1'b0);
    check("R11 busy after reset", busy, 1'b0);

    // R1: software start with hardware disabled
    cur_tag = "R1";
    sw_pulse("R1", 1);
    drain("R1");

    // R2: rising edge on selected timer 2
    cur_tag = "R2";
    hw_enable = 1; src_sel = 3'd2;
    idle(10);
    timer_trig[2] = 1; expect_start("R2", 1);
    // R3: hold high, then fall: nothing more
    cur_tag = "R3";
    idle(40);
    timer_trig[2] = 0;
    drain("R3");

    // R1: software start still works with hardware enabled
    cur_tag = "R1";
    sw_pulse("R1 hw on", 1);
    drain("R1 hw on");

    // R5: unselected source toggles
    cur_tag = "R5";
    for (int i = 0; i < 3; i++) begin
      timer_trig[4] = 1; idle(6);
      timer_trig[4] = 0; idle(6);
    end
    ext_trig = 1; idle(6); ext_trig = 0;
    drain("R5");

    // R4: hardware gated off
    cur_tag = "R4";
    hw_enable = 0; idle(4);
    timer_trig[2] = 1; idle(10);
    timer_trig[2] = 0; idle(10);
    hw_enable = 1;
    drain("R4");

    // R2: external pin via code 6
    cur_tag = "R2";
    src_sel = 3'd6; idle(10);
    ext_trig = 1; expect_start("R2 ext", 1);
    idle(10); ext_trig = 0;
    drain("R2 ext");

    // R6: reserved code 7
    cur_tag = "R6";
    src_sel = 3'd7; idle(10);
    for (int i = 0; i < 2; i++) begin
      timer_trig = '1; ext_trig = 1; idle(6);
      timer_trig = '0; ext_trig = 0; idle(6);
    end
    drain("R6");

    // R7: switch onto a source already high
    cur_tag = "R7";
    src_sel = 3'd2; idle(10);
    timer_trig[5] = 1; idle(10);
    src_sel = 3'd5;
    drain("R7 switch");
    timer_trig[5] = 0; idle(10);
    timer_trig[5] = 1; expect_start("R7 after settle", 1);
    idle(10); timer_trig[5] = 0;
    drain("R7 after settle");

    // R9: three requests on consecutive cycles
    cur_tag = "R9";
    @(negedge sys_clk);
    for (int i = 0; i < 3; i++) begin
      sw_start = 1; expect_start("R9", 0);
      @(negedge sys_clk);
    end
    sw_start = 0;
    check("R9 busy while backlog (R11)", busy, 1'b1);
    drain("R9");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule